// File: doc/BRIEF.md
# Cartridge ROM/RAM Bank Controller

This block sits between an 8-bit CPU bus (16-bit address, 8-bit data, separate read and write strobes) and three targets on a cartridge: a ROM of power-of-two bank count, a banked external RAM, and a small register file holding a snapshot of a real-time clock. CPU writes that land in the lower 32 KiB, which is the ROM window, never reach the ROM. They are decoded as control writes instead. These writes switch the upper 16 KiB ROM view, gate the external RAM, pick a RAM bank or one of the clock registers, and take a snapshot of the clock.

For each bus cycle the block produces the physical ROM address and a ROM read strobe. It also produces the physical RAM address, RAM read and write strobes, and the byte returned for the 0xA000–0xBFFF window. That byte comes from a clock register, from the RAM, or is the open-bus value 0xFF. Live time arrives on input fields: seconds, minutes, hours and a 9-bit day count. The block only samples these fields. It does not count time.

Control writes take effect at the rising clock edge on which the write strobe is high. Address and read-data outputs are combinational from the address and the current control state.

Top module: `cart_bank_ctrl`

## Requirements
- R1: A write to 0x0000–0x1FFF with data 0x0A enables external RAM, and data 0x00 disables it. Any other data leaves the enable unchanged.
- R2: A write to 0x2000–0x3FFF sets the ROM bank select to data & 0x7F. When that value is zero, bank 1 is selected instead.
- R3: A write to 0x4000–0x5FFF with data below RAM_BANKS (0–3 by default) selects that RAM bank and turns clock access off. Data 0x08–0x0C selects clock register (data − 8) and turns clock access on. The registers are: 0 seconds, 1 minutes, 2 hours, 3 day-count low byte, 4 control. Other data values change nothing.
- R4: For addresses below 0x8000, rom_addr_o is {bank, addr[13:0]}. The bank is 0 for 0x0000–0x3FFF and the selected bank for 0x4000–0x7FFF. rom_re_o is rd_i for addresses below 0x8000.
- R5: A read in 0xA000–0xBFFF returns the selected clock register when clock access is on. Otherwise, with RAM enabled, it returns ram_rdata_i and raises ram_re_o. Otherwise it returns 0xFF. ram_addr_o is {RAM bank, addr[12:0]}. rdata_o is 0xFF outside this window.
- R6: A write in 0xA000–0xBFFF follows the same priority. It writes the selected clock register, or raises ram_we_o with ram_wdata_o = wdata_i, or is dropped.
- R7: A write to 0x6000–0x7FFF with data 0x00 arms the snapshot. A following write of 0x01 copies seconds, minutes, hours and day[7:0] into registers 0–3 and disarms. It also sets register 4 to {its bits 7:4, 3'b000, day[8]}. A 0x01 write while unarmed does nothing.
- R8: The ROM bank used for addressing is the selected bank modulo ROM_BANKS, so a select beyond the ROM wraps. A nonzero select that wraps to 0 addresses bank 0.
- R9: After reset: ROM bank 1, RAM bank 0, RAM disabled, clock access off, snapshot unarmed, and all clock registers 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 16 | CPU address |
| wdata_i | input | 8 | CPU write data |
| wr_i | input | 1 | CPU write strobe |
| rd_i | input | 1 | CPU read strobe |
| sec_i | input | 8 | Live seconds |
| min_i | input | 8 | Live minutes |
| hour_i | input | 8 | Live hours |
| day_i | input | 9 | Live day count |
| ram_rdata_i | input | 8 | External RAM read data |
| rom_addr_o | output | 14+log2(ROM_BANKS) | Physical ROM address |
| rom_re_o | output | 1 | ROM read strobe |
| ram_addr_o | output | 13+log2(RAM_BANKS) | Physical RAM address |
| ram_wdata_o | output | 8 | External RAM write data |
| ram_we_o | output | 1 | External RAM write strobe |
| ram_re_o | output | 1 | External RAM read strobe |
| rdata_o | output | 8 | Read data for the RAM/clock window |

## Verification
The bound checker checks several properties on every cycle:
- reads from the fixed lower ROM half never carry a bank;
- a zero bank write lands on bank 1;
- the cycle after a disable or a clock-register select drives no RAM strobe;
- any RAM write strobe is backed by a CPU write into the window with matching data.

Some behaviour depends on values stored over many cycles, and only the directed scenarios can show it:
- RAM contents surviving a disable and re-enable in their own bank;
- clock values frozen between snapshots;
- the arm-then-fire rule of the snapshot;
- the control register's preserved nibble;
- bank wrap at a reduced ROM size.

// File: rtl/cbc_pkg.sv
`timescale 1ns/1ps
package cbc_pkg;
  localparam int unsigned RTC_REGS = 5;

  typedef enum logic [2:0] {
    RTC_SEC  = 3'd0,
    RTC_MIN  = 3'd1,
    RTC_HOUR = 3'd2,
    RTC_DAYL = 3'd3,
    RTC_CTRL = 3'd4
  } rtc_idx_e;

  // control-write decode on addr[14:13] when addr[15] == 0
  typedef enum logic [1:0] {
    CTL_RAM_EN   = 2'd0,
    CTL_ROM_BANK = 2'd1,
    CTL_RAM_SEL  = 2'd2,
    CTL_LATCH    = 2'd3
  } ctl_region_e;

  typedef enum logic [1:0] {
    WIN_RTC  = 2'd0,
    WIN_RAM  = 2'd1,
    WIN_OPEN = 2'd2
  } win_src_e;

  localparam logic [2:0] WIN_TAG   = 3'b101;
  localparam logic [7:0] OPEN_BUS  = 8'hFF;
  localparam logic [7:0] RAM_ON    = 8'h0A;
  localparam logic [7:0] RAM_OFF   = 8'h00;
  localparam logic [7:0] RTC_FIRST = 8'h08;
  localparam logic [7:0] RTC_LAST  = 8'h0C;
endpackage

// File: rtl/cbc_ctrl_regs.sv
`timescale 1ns/1ps
module cbc_ctrl_regs
  import cbc_pkg::*;
#(
  parameter int unsigned ROM_BANKS = 128,
  parameter int unsigned RAM_BANKS = 4,
  localparam int unsigned RB_W = $clog2(ROM_BANKS),
  localparam int unsigned AB_W = (RAM_BANKS > 1) ? $clog2(RAM_BANKS) : 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [2:0]      addr_hi_i,
  input  logic [7:0]      wdata_i,
  input  logic            wr_i,
  output logic [RB_W-1:0] rom_bank_o,
  output logic [AB_W-1:0] ram_bank_o,
  output logic            ram_en_o,
  output logic            rtc_on_o,
  output rtc_idx_e        rtc_sel_o,
  output logic            latch_o
);
  logic [6:0]      rom_sel_q;
  logic [AB_W-1:0] ram_bank_q;
  logic            ram_en_q, rtc_on_q, armed_q;
  rtc_idx_e        rtc_sel_q;

  logic        ctl_wr;
  ctl_region_e region;
  logic [6:0]  bank_req;
  logic        ram_sel_ok, rtc_sel_ok;

  assign ctl_wr     = wr_i && !addr_hi_i[2];
  assign region     = ctl_region_e'(addr_hi_i[1:0]);
  assign bank_req   = (wdata_i[6:0] == 7'd0) ? 7'd1 : wdata_i[6:0];
  assign ram_sel_ok = ({24'd0, wdata_i} < RAM_BANKS);
  assign rtc_sel_ok = (wdata_i >= RTC_FIRST) && (wdata_i <= RTC_LAST);
  assign latch_o    = ctl_wr && (region == CTL_LATCH) && armed_q && (wdata_i == 8'h01);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rom_sel_q  <= 7'd1;
      ram_bank_q <= '0;
      ram_en_q   <= 1'b0;
      rtc_on_q   <= 1'b0;
      rtc_sel_q  <= RTC_SEC;
      armed_q    <= 1'b0;
    end else if (ctl_wr) begin
      unique case (region)
        CTL_RAM_EN: begin
          if (wdata_i == RAM_ON)       ram_en_q <= 1'b1;
          else if (wdata_i == RAM_OFF) ram_en_q <= 1'b0;
        end
        CTL_ROM_BANK: rom_sel_q <= bank_req;
        CTL_RAM_SEL: begin
          if (ram_sel_ok) begin
            ram_bank_q <= wdata_i[AB_W-1:0];
            rtc_on_q   <= 1'b0;
          end else if (rtc_sel_ok) begin
            rtc_sel_q <= rtc_idx_e'(wdata_i[2:0] - 3'd0);
            rtc_on_q  <= 1'b1;
          end
        end
        CTL_LATCH: begin
          if (wdata_i == 8'h00)      armed_q <= 1'b1;
          else if (latch_o)          armed_q <= 1'b0;
        end
        default: ;
      endcase
    end
  end

  // 0x08..0x0C: low three bits minus 8 is just bits[2:0] since bit3 set
  assign rom_bank_o = rom_sel_q[RB_W-1:0];
  assign ram_bank_o = ram_bank_q;
  assign ram_en_o   = ram_en_q;
  assign rtc_on_o   = rtc_on_q;
  assign rtc_sel_o  = rtc_sel_q;
endmodule

// File: rtl/cbc_rtc_file.sv
`timescale 1ns/1ps
module cbc_rtc_file
  import cbc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       we_i,
  input  rtc_idx_e   sel_i,
  input  logic [7:0] wdata_i,
  input  logic       latch_i,
  input  logic [7:0] sec_i,
  input  logic [7:0] min_i,
  input  logic [7:0] hour_i,
  input  logic [8:0] day_i,
  output logic [7:0] rdata_o
);
  logic [7:0] regs_q [RTC_REGS];
  logic [7:0] snap   [RTC_REGS];

  assign snap[RTC_SEC]  = sec_i;
  assign snap[RTC_MIN]  = min_i;
  assign snap[RTC_HOUR] = hour_i;
  assign snap[RTC_DAYL] = day_i[7:0];
  assign snap[RTC_CTRL] = {regs_q[RTC_CTRL][7:4], 3'b000, day_i[8]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < RTC_REGS; i++) regs_q[i] <= 8'h00;
    end else if (latch_i) begin
      for (int i = 0; i < RTC_REGS; i++) regs_q[i] <= snap[i];
    end else if (we_i) begin
      for (int i = 0; i < RTC_REGS; i++)
        if (sel_i == rtc_idx_e'(i)) regs_q[i] <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = OPEN_BUS;
    for (int i = 0; i < RTC_REGS; i++)
      if (sel_i == rtc_idx_e'(i)) rdata_o = regs_q[i];
  end
endmodule

// File: rtl/cbc_addr_map.sv
`timescale 1ns/1ps
module cbc_addr_map
  import cbc_pkg::*;
#(
  parameter int unsigned ROM_BANKS = 128,
  parameter int unsigned RAM_BANKS = 4,
  localparam int unsigned RB_W   = $clog2(ROM_BANKS),
  localparam int unsigned AB_W   = (RAM_BANKS > 1) ? $clog2(RAM_BANKS) : 1,
  localparam int unsigned ROM_AW = 14 + RB_W,
  localparam int unsigned RAM_AW = 13 + ((RAM_BANKS > 1) ? $clog2(RAM_BANKS) : 0)
) (
  input  logic [15:0]       addr_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [RB_W-1:0]   rom_bank_i,
  input  logic [AB_W-1:0]   ram_bank_i,
  input  logic              ram_en_i,
  input  logic              rtc_on_i,
  input  logic [7:0]        rtc_rdata_i,
  input  logic [7:0]        ram_rdata_i,
  output logic [ROM_AW-1:0] rom_addr_o,
  output logic              rom_re_o,
  output logic [RAM_AW-1:0] ram_addr_o,
  output logic              ram_we_o,
  output logic              ram_re_o,
  output logic              rtc_we_o,
  output logic [7:0]        rdata_o
);
  logic     in_win;
  win_src_e src;

  assign in_win = (addr_i[15:13] == WIN_TAG);
  assign src    = rtc_on_i ? WIN_RTC : (ram_en_i ? WIN_RAM : WIN_OPEN);

  assign rom_addr_o = {(addr_i[14] ? rom_bank_i : {RB_W{1'b0}}), addr_i[13:0]};
  assign rom_re_o   = rd_i && !addr_i[15];

  if (RAM_BANKS > 1) begin : g_ram_banked
    assign ram_addr_o = {ram_bank_i, addr_i[12:0]};
  end else begin : g_ram_flat
    logic unused_bank;
    assign unused_bank = ^ram_bank_i;
    assign ram_addr_o  = addr_i[12:0];
  end

  assign ram_we_o = wr_i && in_win && (src == WIN_RAM);
  assign ram_re_o = rd_i && in_win && (src == WIN_RAM);
  assign rtc_we_o = wr_i && in_win && (src == WIN_RTC);

  always_comb begin
    rdata_o = OPEN_BUS;
    if (in_win) begin
      unique case (src)
        WIN_RTC: rdata_o = rtc_rdata_i;
        WIN_RAM: rdata_o = ram_rdata_i;
        default: rdata_o = OPEN_BUS;
      endcase
    end
  end
endmodule

// File: rtl/cart_bank_ctrl.sv
`timescale 1ns/1ps
module cart_bank_ctrl
  import cbc_pkg::*;
#(
  parameter int unsigned ROM_BANKS = 128,
  parameter int unsigned RAM_BANKS = 4,
  localparam int unsigned RB_W   = $clog2(ROM_BANKS),
  localparam int unsigned AB_W   = (RAM_BANKS > 1) ? $clog2(RAM_BANKS) : 1,
  localparam int unsigned ROM_AW = 14 + RB_W,
  localparam int unsigned RAM_AW = 13 + ((RAM_BANKS > 1) ? $clog2(RAM_BANKS) : 0)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [15:0]       addr_i,
  input  logic [7:0]        wdata_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [7:0]        sec_i,
  input  logic [7:0]        min_i,
  input  logic [7:0]        hour_i,
  input  logic [8:0]        day_i,
  input  logic [7:0]        ram_rdata_i,
  output logic [ROM_AW-1:0] rom_addr_o,
  output logic              rom_re_o,
  output logic [RAM_AW-1:0] ram_addr_o,
  output logic [7:0]        ram_wdata_o,
  output logic              ram_we_o,
  output logic              ram_re_o,
  output logic [7:0]        rdata_o
);
  logic [RB_W-1:0] rom_bank;
  logic [AB_W-1:0] ram_bank;
  logic            ram_en, rtc_on, latch, rtc_we;
  rtc_idx_e        rtc_sel;
  logic [7:0]      rtc_rdata;

  cbc_ctrl_regs #(.ROM_BANKS(ROM_BANKS), .RAM_BANKS(RAM_BANKS)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .addr_hi_i  (addr_i[15:13]),
    .wdata_i    (wdata_i),
    .wr_i       (wr_i),
    .rom_bank_o (rom_bank),
    .ram_bank_o (ram_bank),
    .ram_en_o   (ram_en),
    .rtc_on_o   (rtc_on),
    .rtc_sel_o  (rtc_sel),
    .latch_o    (latch)
  );

  cbc_rtc_file u_rtc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (rtc_we),
    .sel_i   (rtc_sel),
    .wdata_i (wdata_i),
    .latch_i (latch),
    .sec_i   (sec_i),
    .min_i   (min_i),
    .hour_i  (hour_i),
    .day_i   (day_i),
    .rdata_o (rtc_rdata)
  );

  cbc_addr_map #(.ROM_BANKS(ROM_BANKS), .RAM_BANKS(RAM_BANKS)) u_map (
    .addr_i      (addr_i),
    .rd_i        (rd_i),
    .wr_i        (wr_i),
    .rom_bank_i  (rom_bank),
    .ram_bank_i  (ram_bank),
    .ram_en_i    (ram_en),
    .rtc_on_i    (rtc_on),
    .rtc_rdata_i (rtc_rdata),
    .ram_rdata_i (ram_rdata_i),
    .rom_addr_o  (rom_addr_o),
    .rom_re_o    (rom_re_o),
    .ram_addr_o  (ram_addr_o),
    .ram_we_o    (ram_we_o),
    .ram_re_o    (ram_re_o),
    .rtc_we_o    (rtc_we),
    .rdata_o     (rdata_o)
  );

  assign ram_wdata_o = wdata_i;
endmodule

// File: rtl/cbc_checker.sv
`timescale 1ns/1ps
module cbc_checker #(
  parameter int unsigned ROM_BANKS = 128,
  localparam int unsigned RB_W   = $clog2(ROM_BANKS),
  localparam int unsigned ROM_AW = 14 + RB_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [15:0]       addr_i,
  input logic [7:0]        wdata_i,
  input logic              wr_i,
  input logic              rd_i,
  input logic [ROM_AW-1:0] rom_addr_o,
  input logic [7:0]        ram_wdata_o,
  input logic              ram_we_o,
  input logic              ram_re_o
);
  a_r4_bank0_fixed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i[15:14] == 2'b00) |-> (rom_addr_o[ROM_AW-1:14] == '0));

  a_r2_zero_forced: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i[15:13] == 3'b001 && wdata_i[6:0] == 7'd0)
    |=> (addr_i[15:14] != 2'b01 || rom_addr_o[ROM_AW-1:14] == RB_W'(1)));

  a_r1_ram_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i[15:13] == 3'b000 && wdata_i == 8'h00)
    |=> (!ram_we_o && !ram_re_o));

  a_r3_rtc_priority: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i[15:13] == 3'b010 && wdata_i >= 8'h08 && wdata_i <= 8'h0C)
    |=> (!ram_we_o && !ram_re_o));

  a_r6_we_qualified: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_we_o |-> (wr_i && addr_i[15:13] == 3'b101 && ram_wdata_o == wdata_i));

  a_r5_re_qualified: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_re_o |-> (rd_i && addr_i[15:13] == 3'b101));
endmodule

bind cart_bank_ctrl cbc_checker #(.ROM_BANKS(ROM_BANKS)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .addr_i      (addr_i),
  .wdata_i     (wdata_i),
  .wr_i        (wr_i),
  .rd_i        (rd_i),
  .rom_addr_o  (rom_addr_o),
  .ram_wdata_o (ram_wdata_o),
  .ram_we_o    (ram_we_o),
  .ram_re_o    (ram_re_o)
);

// File: tb/tb_cart_bank_ctrl.sv
`timescale 1ns/1ps
module tb_cart_bank_ctrl;
  localparam int unsigned ROM_BANKS = 32;
  localparam int unsigned RAM_BANKS = 4;
  localparam int unsigned ROM_AW = 14 + $clog2(ROM_BANKS);
  localparam int unsigned RAM_AW = 13 + $clog2(RAM_BANKS);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic wr = 1'b0, rd = 1'b0;
  logic [7:0] sec = '0, mins = '0, hour = '0;
  logic [8:0] day = '0;
  logic [7:0] ram_rdata;
  logic [ROM_AW-1:0] rom_addr;
  logic rom_re;
  logic [RAM_AW-1:0] ram_addr;
  logic [7:0] ram_wdata;
  logic ram_we, ram_re;
  logic [7:0] rdata;

  int tests = 0, fails = 0;
  bit done = 1'b0;
  logic [7:0] mem [RAM_BANKS*8192];

  always #2.5 clk = ~clk;

  cart_bank_ctrl #(.ROM_BANKS(ROM_BANKS), .RAM_BANKS(RAM_BANKS)) dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata), .wr_i(wr), .rd_i(rd),
    .sec_i(sec), .min_i(mins), .hour_i(hour), .day_i(day), .ram_rdata_i(ram_rdata),
    .rom_addr_o(rom_addr), .rom_re_o(rom_re), .ram_addr_o(ram_addr),
    .ram_wdata_o(ram_wdata), .ram_we_o(ram_we), .ram_re_o(ram_re), .rdata_o(rdata)
  );

  assign ram_rdata = mem[ram_addr];
  always @(posedge clk) if (ram_we) mem[ram_addr] <= ram_wdata;

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic cpu_wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic cpu_rd(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a; rd = 1'b1;
    #1;
    d = rdata;
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    @(negedge clk); addr = 16'h4000; rd = 1'b1; #1;
    chk("R9 rom bank 1", int'(rom_addr), 32'h4000);
    chk("R4 rom_re", int'(rom_re), 1);
    rd = 1'b0;
    cpu_rd(16'hA010, d);
    chk("R9 ram disabled reads FF", d, 8'hFF);
    @(negedge clk); addr = 16'hA010; #1;
    chk("R9 ram bank 0", int'(ram_addr), 32'h0010);
  endtask

  task automatic t_rom_bank();
    cpu_wr(16'h2000, 8'h05);
    @(negedge clk); addr = 16'h4123; #1;
    chk("R4 bank 5 addr", int'(rom_addr), 32'h14123);
    addr = 16'h1234; #1;
    chk("R4 lower half bank 0", int'(rom_addr), 32'h1234);
    cpu_wr(16'h3FFF, 8'h00);
    @(negedge clk); addr = 16'h7FFF; #1;
    chk("R2 zero forced to 1", int'(rom_addr), 32'h7FFF);
    cpu_wr(16'h2000, 8'h80);
    @(negedge clk); addr = 16'h4000; #1;
    chk("R2 0x80 masks to zero -> 1", int'(rom_addr), 32'h4000);
    cpu_wr(16'h2000, 8'h25);
    @(negedge clk); addr = 16'h4001; #1;
    chk("R8 0x25 wraps to 5", int'(rom_addr), 32'h14001);
    cpu_wr(16'h2000, 8'h20);
    @(negedge clk); addr = 16'h4002; #1;
    chk("R8 0x20 wraps to 0", int'(rom_addr), 32'h0002);
    @(negedge clk); addr = 16'hA000; rd = 1'b1; #1;
    chk("R4 rom_re low outside ROM", int'(rom_re), 0);
    rd = 1'b0;
  endtask

  task automatic t_ram();
    logic [7:0] d;
    cpu_wr(16'hA010, 8'h11);
    cpu_wr(16'h0000, 8'h0A);
    cpu_rd(16'hA010, d);
    chk("R6 write while disabled dropped", d, 8'h00);
    cpu_wr(16'hA010, 8'h5C);
    cpu_rd(16'hA010, d);
    chk("R5 ram read bank0", d, 8'h5C);
    cpu_wr(16'h4000, 8'h02);
    cpu_wr(16'hA010, 8'h77);
    @(negedge clk); addr = 16'hA010; #1;
    chk("R5 ram_addr bank2", int'(ram_addr), 32'h4010);
    cpu_rd(16'hA010, d);
    chk("R3 bank2 data", d, 8'h77);
    cpu_wr(16'h1000, 8'h33);
    cpu_rd(16'hA010, d);
    chk("R1 other value keeps enable", d, 8'h77);
    cpu_wr(16'h0000, 8'h00);
    cpu_rd(16'hA010, d);
    chk("R1 disabled reads FF", d, 8'hFF);
    cpu_wr(16'hA010, 8'h99);
    cpu_wr(16'h0000, 8'h0A);
    cpu_rd(16'hA010, d);
    chk("R6 dropped write left RAM", d, 8'h77);
    cpu_wr(16'h4000, 8'h00);
    cpu_rd(16'hA010, d);
    chk("R3 back to bank0", d, 8'h5C);
    cpu_rd(16'hC000, d);
    chk("R5 outside window FF", d, 8'hFF);
  endtask

  task automatic t_rtc();
    logic [7:0] d;
    sec = 8'd12; mins = 8'd34; hour = 8'd5; day = 9'h1A3;
    cpu_wr(16'h4000, 8'h08);
    cpu_wr(16'h6000, 8'h01);
    cpu_rd(16'hA000, d);
    chk("R7 unarmed latch ignored", d, 8'h00);
    cpu_wr(16'h6000, 8'h00);
    cpu_wr(16'h6000, 8'h01);
    cpu_rd(16'hA000, d);
    chk("R7 seconds latched", d, 8'd12);
    cpu_wr(16'h5000, 8'h09);
    cpu_rd(16'hA000, d);
    chk("R7 minutes latched", d, 8'd34);
    cpu_wr(16'h4000, 8'h0B);
    cpu_rd(16'hBFFF, d);
    chk("R7 day low latched", d, 8'hA3);
    cpu_wr(16'h4000, 8'h0C);
    cpu_rd(16'hA000, d);
    chk("R7 ctrl day bit8", d, 8'h01);
    cpu_wr(16'hA000, 8'hFE);
    cpu_rd(16'hA000, d);
    chk("R6 ctrl register write", d, 8'hFE);
    sec = 8'd40;
    cpu_wr(16'h6000, 8'h01);
    cpu_rd(16'hA000, d);
    chk("R7 disarmed after latch", d, 8'hFE);
    cpu_wr(16'h6000, 8'h00);
    cpu_wr(16'h6000, 8'h01);
    cpu_rd(16'hA000, d);
    chk("R7 ctrl keeps upper nibble", d, 8'hF1);
    cpu_wr(16'h4000, 8'h05);
    cpu_rd(16'hA000, d);
    chk("R3 value 5 ignored", d, 8'hF1);
    cpu_wr(16'h4000, 8'h08);
    cpu_wr(16'hA123, 8'h99);
    cpu_rd(16'hA000, d);
    chk("R5 rtc priority over ram", d, 8'h99);
    cpu_wr(16'h4000, 8'h02);
    cpu_rd(16'hA123, d);
    chk("R6 rtc write missed RAM", d, 8'h00);
    cpu_wr(16'h0000, 8'h00);
    cpu_wr(16'h4000, 8'h0A);
    cpu_rd(16'hA000, d);
    chk("R5 rtc read with RAM off", d, 8'd5);
  endtask

  initial begin
    for (int i = 0; i < RAM_BANKS*8192; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_rom_bank();
    t_ram();
    t_rtc();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule